// File: doc/BRIEF.md
# Dual-Write Register File

This block is a small bank of general-purpose registers that two independent writers and two independent readers can use in the same clock cycle. Each write port brings its own enable, register index and data word. Each index is decoded into a one-hot set of load enables. Every register then takes its next value through a two-way selector that chooses between the two write words.

When both writers name the same register in one cycle, a fixed priority settles it: write port A wins and port B's word is dropped. The two read ports are purely combinational selectors over the stored registers. A read returns the value held before the coming clock edge, so a word written in a cycle can be seen only from the following cycle. A synchronous, active-high reset clears every register and takes precedence over both writers.

Top module: `dualwr_regfile`

## Requirements
- R1: After a clock edge with `rst` high, every register holds zero, so both read ports return 0 for any index until a register is written again.
- R2: While `rst` is high, neither write port changes any register: after the reset edge the written indices still read 0.
- R3: When `wa_en` is 1 at a clock edge, the register at index `wa_addr` holds `wa_data` after that edge.
- R4: When `wb_en` is 1 at a clock edge, the register at index `wb_addr` holds `wb_data` after that edge, unless port A writes the same index in that cycle.
- R5: When both ports write different indices in one cycle, both registers take their new words on the same edge, and no other register changes.
- R6: When both ports are enabled with equal indices, the register takes `wa_data` and `wb_data` is discarded.
- R7: A port whose enable is 0 writes nothing: its address and data inputs change no register.
- R8: A read is combinational. A write issued in the current cycle does not show on either read port before the clock edge; it shows right after it.
- R9: Each read port selects the register at its own index (index i selects register i, with i from 0 to NREG-1). The two ports are independent, and the same index on both ports returns the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wa_en | input | 1 | Write port A enable (higher priority) |
| wa_addr | input | AW | Write port A register index |
| wa_data | input | WIDTH | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | AW | Write port B register index |
| wb_data | input | WIDTH | Write port B data |
| ra_addr | input | AW | Read port A register index |
| ra_data | output | WIDTH | Read port A data (combinational) |
| rb_addr | input | AW | Read port B register index |
| rb_data | output | WIDTH | Read port B data (combinational) |

## Verification
Both read results follow a change of read index in the same cycle, with no register on the path. A write or a clear becomes visible exactly one rising edge after it is presented. The bench drives its inputs on the falling edge and checks both read ports 1 ns later, before the rising edge. At that point the expected value is still the old one, which is what R8 requires. The behavioural model is updated only at the rising edge, so the next cycle's check compares against the post-edge contents.

// File: rtl/rf2w_pkg.sv
package rf2w_pkg;

  localparam int DEF_NREG  = 8;
  localparam int DEF_WIDTH = 8;

  // which write port feeds a register's data input
  typedef enum logic {
    SEL_PORT_A = 1'b0,
    SEL_PORT_B = 1'b1
  } wsel_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode #(
  parameter int NREG = 8,
  parameter int AW   = 3
) (
  input  logic            en,
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit
);
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hit[i] = en && (addr == AW'(i));
    end
  end
endmodule

// File: rtl/rf_prio_cell.sv
module rf_prio_cell
  import rf2w_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_a,
  input  logic             ld_b,
  input  logic [WIDTH-1:0] d_a,
  input  logic [WIDTH-1:0] d_b,
  output logic [WIDTH-1:0] q
);
  wsel_e            sel;
  logic             load;
  logic [WIDTH-1:0] d_in;

  // port A takes the mux whenever its decoded enable is set
  assign sel  = ld_a ? SEL_PORT_A : SEL_PORT_B;
  assign load = ld_a | ld_b;
  assign d_in = (sel == SEL_PORT_A) ? d_a : d_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d_in;
    end
  end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
  parameter int NREG  = 8,
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic [NREG*WIDTH-1:0] regs_flat,
  input  logic [AW-1:0]         addr,
  output logic [WIDTH-1:0]      dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i)) begin
        dout = regs_flat[i*WIDTH +: WIDTH];
      end
    end
  end
endmodule

// File: rtl/dualwr_regfile.sv
module dualwr_regfile
  import rf2w_pkg::*;
#(
  parameter int NREG  = DEF_NREG,
  parameter int WIDTH = DEF_WIDTH,
  parameter int AW    = idx_bits(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wa_en,
  input  logic [AW-1:0]    wa_addr,
  input  logic [WIDTH-1:0] wa_data,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_addr,
  input  logic [WIDTH-1:0] wb_data,
  input  logic [AW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_data,
  input  logic [AW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_data
);
  localparam int NWP = 2;
  localparam int NRP = 2;

  logic [NREG-1:0]       hit     [NWP];
  logic                  wen     [NWP];
  logic [AW-1:0]         waddr   [NWP];
  logic [NREG*WIDTH-1:0] regs_flat;
  logic [AW-1:0]         raddr   [NRP];
  logic [WIDTH-1:0]      rdata   [NRP];

  assign wen[0]   = wa_en;
  assign wen[1]   = wb_en;
  assign waddr[0] = wa_addr;
  assign waddr[1] = wb_addr;
  assign raddr[0] = ra_addr;
  assign raddr[1] = rb_addr;
  assign ra_data  = rdata[0];
  assign rb_data  = rdata[1];

  for (genvar p = 0; p < NWP; p++) begin : g_dec
    rf_addr_decode #(.NREG(NREG), .AW(AW)) u_dec (
      .en   (wen[p]),
      .addr (waddr[p]),
      .hit  (hit[p])
    );
  end

  for (genvar r = 0; r < NREG; r++) begin : g_cell
    rf_prio_cell #(.WIDTH(WIDTH)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .ld_a (hit[0][r]),
      .ld_b (hit[1][r]),
      .d_a  (wa_data),
      .d_b  (wb_data),
      .q    (regs_flat[r*WIDTH +: WIDTH])
    );
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    rf_read_sel #(.NREG(NREG), .WIDTH(WIDTH), .AW(AW)) u_rd (
      .regs_flat (regs_flat),
      .addr      (raddr[p]),
      .dout      (rdata[p])
    );
  end
endmodule

// File: rtl/dualwr_regfile_chk.sv
module dualwr_regfile_chk #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wa_en,
  input logic [AW-1:0]    wa_addr,
  input logic [WIDTH-1:0] wa_data,
  input logic             wb_en,
  input logic [AW-1:0]    wb_addr,
  input logic [WIDTH-1:0] wb_data,
  input logic [AW-1:0]    ra_addr,
  input logic [WIDTH-1:0] ra_data,
  input logic [AW-1:0]    rb_addr,
  input logic [WIDTH-1:0] rb_data
);
  // R1
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ra_data == '0) && (rb_data == '0));

  // R3
  wa_lands_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wa_en && !rst) && (ra_addr == $past(wa_addr)))
      |-> (ra_data == $past(wa_data)));

  // R4
  wb_lands_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wb_en && !rst && !(wa_en && (wa_addr == wb_addr)))
      && (rb_addr == $past(wb_addr)))
      |-> (rb_data == $past(wb_data)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!wa_en && !wb_en && !rst) && (ra_addr == $past(ra_addr)))
      |-> $stable(ra_data));

  // R9
  same_index_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_addr == rb_addr) |-> (ra_data == rb_data));
endmodule

bind dualwr_regfile dualwr_regfile_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wa_en   (wa_en),
  .wa_addr (wa_addr),
  .wa_data (wa_data),
  .wb_en   (wb_en),
  .wb_addr (wb_addr),
  .wb_data (wb_data),
  .ra_addr (ra_addr),
  .ra_data (ra_data),
  .rb_addr (rb_addr),
  .rb_data (rb_data)
);

// File: tb/dualwr_regfile_bench.sv
`timescale 1ns/1ps
module dualwr_regfile_bench;
  localparam int NREG  = 8;
  localparam int WIDTH = 8;
  localparam int AW    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wa_en = 1'b0, wb_en = 1'b0;
  logic [AW-1:0]    wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [WIDTH-1:0] wa_data = '0, wb_data = '0;
  logic [WIDTH-1:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;
  int model [NREG];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dualwr_regfile u_dualwr_regfile (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs are set by the caller just after a falling edge
  task automatic cyc(input string tag);
    #1;
    check({tag, " read A"}, int'(ra_data), model[ra_addr]);
    check({tag, " read B"}, int'(rb_data), model[rb_addr]);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NREG; i++) model[i] = 0;
    end else begin
      if (wb_en) model[wb_addr] = int'(wb_data);
      if (wa_en) model[wa_addr] = int'(wa_data);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wa_en = 1'b0;
    wb_en = 1'b0;
  endtask

  task automatic dump(input string tag);
    idle();
    for (int i = 0; i < NREG; i++) begin
      ra_addr = AW'(i);
      rb_addr = AW'(NREG - 1 - i);
      cyc(tag);
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 0;
    @(negedge clk);
    // R2: writes offered during reset
    rst = 1'b1; wa_en = 1'b1; wa_addr = 3'd4; wa_data = 8'hF0;
    wb_en = 1'b1; wb_addr = 3'd6; wb_data = 8'h0F;
    @(posedge clk); @(negedge clk);
    cyc("R2");
    rst = 1'b0;
    dump("R1 R2");

    // R3
    wa_en = 1'b1; wa_addr = 3'd3; wa_data = 8'hA5; ra_addr = 3'd3;
    cyc("R3");
    idle(); cyc("R3");
    // R4
    wb_en = 1'b1; wb_addr = 3'd5; wb_data = 8'h3C; rb_addr = 3'd5;
    cyc("R4");
    idle(); cyc("R4");
    // R5
    wa_en = 1'b1; wa_addr = 3'd1; wa_data = 8'h11;
    wb_en = 1'b1; wb_addr = 3'd6; wb_data = 8'h66;
    ra_addr = 3'd1; rb_addr = 3'd6;
    cyc("R5");
    dump("R5");
    // R6
    wa_en = 1'b1; wa_addr = 3'd2; wa_data = 8'hAA;
    wb_en = 1'b1; wb_addr = 3'd2; wb_data = 8'hBB;
    ra_addr = 3'd2; rb_addr = 3'd2;
    cyc("R6");
    idle(); cyc("R6");
    check("R6 port A wins", int'(ra_data), 8'hAA);
    // R7
    for (int k = 0; k < 6; k++) begin
      idle();
      wa_addr = AW'(k); wa_data = 8'hE0 + 8'(k);
      wb_addr = AW'(k + 1); wb_data = 8'hD0 + 8'(k);
      ra_addr = AW'(k); rb_addr = AW'(k + 1);
      cyc("R7");
    end
    dump("R7");
    // R8
    wa_en = 1'b1; wa_addr = 3'd3; wa_data = 8'h77; ra_addr = 3'd3;
    wb_en = 1'b1; wb_addr = 3'd0; wb_data = 8'h99; rb_addr = 3'd0;
    #1;
    check("R8 old value before edge A", int'(ra_data), 8'hA5);
    check("R8 old value before edge B", int'(rb_data), 0);
    cyc("R8");
    idle(); cyc("R8");
    check("R8 new value after edge", int'(ra_data), 8'h77);
    // R9
    for (int k = 0; k < NREG; k++) begin
      ra_addr = AW'(k); rb_addr = AW'(k);
      cyc("R9");
    end
    // random mix
    for (int n = 0; n < 400; n++) begin
      wa_en = 1'($urandom); wb_en = 1'($urandom);
      wa_addr = AW'($urandom); wb_addr = AW'($urandom);
      wa_data = WIDTH'($urandom); wb_data = WIDTH'($urandom);
      ra_addr = AW'($urandom); rb_addr = AW'($urandom);
      rst = ($urandom_range(0, 49) == 0);
      cyc("R3 R4 R6 random");
    end
    rst = 1'b0;
    dump("R9 final");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule